// File: doc/BRIEF.md
# Atomic Coefficient Safe-Load Unit

This unit lets a host change a group of related parameter RAM words, such as the five coefficients of one biquad section, while the DSP program keeps running. The host loads up to five staging slots. Each slot holds a RAM address and a 22-bit data word. The host then pulses an arm request. From that point the unit waits for the program sequencer to announce a stretch in which the parameter RAM is free. Inside that stretch it writes the staged words back to back, so the DSP never runs with a mix of old and new coefficients.

Only slots that were loaded since the previous transfer are written. A slot that was not touched is skipped, even if it still holds an older word. When the burst is over, the unit raises a done flag that the host clears with a read strobe. While a transfer is armed or in progress, the staging slots are locked: host loads are refused and flagged. The sequencer is responsible for announcing the free window early enough that every armed transfer finishes within one audio frame.

Top module: `safeload_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `pending`, `doneFlag`, `ramWrEn` and `hostWrReject` are all 0, and no slot counts as loaded.
- R2: A host write to slot 0..4 while `pending` is 0 stores the address and data in that slot and marks it loaded. A later write to the same slot replaces the earlier values.
- R3: An `initReq` pulse while `pending` is 0 sets `pending` from the next cycle. No RAM write occurs until `windowStart` is seen while `pending` is 1.
- R4: If `windowStart` is high while armed, the free window starts. Call the cycle of that `windowStart` cycle 0. Slot k is issued in cycle k, for k = 0..4. If slot k is loaded, `ramWrEn` is 1 in cycle k with that slot's address and data on `ramWrAddr` and `ramWrData`. All writes fall within the five-cycle window.
- R5: A slot that was not loaded since the last transfer gives `ramWrEn` = 0 in its cycle.
- R6: After cycle 4 of the window, `pending` returns to 0 and `doneFlag` becomes 1 on the same clock edge. All loaded marks are cleared, so a new transfer armed without new host writes issues no RAM writes.
- R7: `doneRead` clears `doneFlag` on the next edge. If a transfer completes on the same edge, setting the flag wins.
- R8: A host write while `pending` is 1 is ignored. The same is true of a write to a slot index of 5 or more. In both cases `hostWrReject` is 1 in that cycle.
- R9: `initReq` while `pending` is 1 has no effect on the transfer in progress. `windowStart` while `pending` is 0 causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host staging-slot write strobe |
| hostWrSlot | input | 3 | Slot index to load |
| hostWrAddr | input | 8 | Parameter RAM address for the slot |
| hostWrData | input | 22 | Parameter word for the slot |
| hostWrReject | output | 1 | The host write in this cycle was refused |
| initReq | input | 1 | Arm-transfer request (self-clearing) |
| pending | output | 1 | Transfer armed or in progress |
| windowStart | input | 1 | Sequencer: RAM free this cycle and the next four |
| ramWrEn | output | 1 | Parameter RAM write enable |
| ramWrAddr | output | 8 | Parameter RAM write address |
| ramWrData | output | 22 | Parameter RAM write data |
| doneRead | input | 1 | Host read strobe of the done flag |
| doneFlag | output | 1 | Transfer complete, clear-on-read |

## Verification
The assertions assume that `windowStart` really does mean the RAM is free for five cycles starting with the current one. The unit has no way to check this. It also ignores any `windowStart` pulse that arrives during a burst. The assertions further assume that `doneRead` is a host strobe that may arrive in any cycle, including the cycle in which a transfer finishes. The stimulus places `windowStart` on arbitrary cycles, including cycles while idle and during a burst, to exercise these rules. It also aims `doneRead` at the completion edge to test flag priority. Host writes are driven during pending periods and to out-of-range slots.

// File: rtl/safeload_pkg.sv
package safeload_pkg;
  parameter int SLOTS = 5;
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  typedef struct packed {
    logic             hostLoad;  // accept host write into a slot
    logic             issue;     // a slot is being issued this cycle
    logic [IDX_W-1:0] scanIdx;   // slot being issued
    logic             finish;    // last slot of the window
  } ctrlStrobe_t;
endpackage

// File: rtl/safeload_ctrl.sv
module safeload_ctrl
  import safeload_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrEn,
  input  logic [IDX_W-1:0] hostWrSlot,
  input  logic             initReq,
  input  logic             windowStart,
  output ctrlStrobe_t      strobe,
  output logic             pending,
  output logic             hostWrReject
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_SCAN} state_t;
  state_t           state;
  logic [IDX_W-1:0] scanIdx;
  logic             slotOk;
  logic             issueNow;
  logic [IDX_W-1:0] curIdx;

  always_comb begin
    slotOk       = int'(hostWrSlot) < SLOTS;
    issueNow     = (state == ST_ARMED && windowStart) || (state == ST_SCAN);
    curIdx       = (state == ST_SCAN) ? scanIdx : '0;
    strobe.hostLoad = hostWrEn && (state == ST_IDLE) && slotOk;
    strobe.issue    = issueNow;
    strobe.scanIdx  = curIdx;
    strobe.finish   = issueNow && (curIdx == LAST_IDX);
    hostWrReject = hostWrEn && !strobe.hostLoad;
    pending      = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      scanIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (initReq) state <= ST_ARMED;
        ST_ARMED: if (windowStart) begin
          if (strobe.finish) state <= ST_IDLE;
          else begin
            state   <= ST_SCAN;
            scanIdx <= IDX_W'(1);
          end
        end
        ST_SCAN: begin
          if (strobe.finish) begin
            state   <= ST_IDLE;
            scanIdx <= '0;
          end else scanIdx <= scanIdx + IDX_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/safeload_dp.sv
module safeload_dp
  import safeload_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  hostWrSlot,
  input  logic [ADDR_W-1:0] hostWrAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              doneRead,
  output logic              ramWrEn,
  output logic [ADDR_W-1:0] ramWrAddr,
  output logic [DATA_W-1:0] ramWrData,
  output logic              doneFlag
);
  logic [ADDR_W-1:0] slotAddr [SLOTS];
  logic [DATA_W-1:0] slotData [SLOTS];
  logic [SLOTS-1:0]  loaded;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic hit;
    assign hit = strobe.hostLoad && (int'(hostWrSlot) == k);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotAddr[k] <= '0;
        slotData[k] <= '0;
        loaded[k]   <= 1'b0;
      end else begin
        if (hit) begin
          slotAddr[k] <= hostWrAddr;
          slotData[k] <= hostWrData;
        end
        if (strobe.finish)  loaded[k] <= 1'b0;
        else if (hit)       loaded[k] <= 1'b1;
      end
    end
  end

  always_comb begin
    ramWrEn   = 1'b0;
    ramWrAddr = '0;
    ramWrData = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (strobe.issue && int'(strobe.scanIdx) == k) begin
        ramWrEn   = loaded[k];
        ramWrAddr = slotAddr[k];
        ramWrData = slotData[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              doneFlag <= 1'b0;
    else if (strobe.finish) doneFlag <= 1'b1;
    else if (doneRead)      doneFlag <= 1'b0;
  end
endmodule

// File: rtl/safeload_unit.sv
module safeload_unit
  import safeload_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [IDX_W-1:0]  hostWrSlot,
  input  logic [ADDR_W-1:0] hostWrAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic              hostWrReject,
  input  logic              initReq,
  output logic              pending,
  input  logic              windowStart,
  output logic              ramWrEn,
  output logic [ADDR_W-1:0] ramWrAddr,
  output logic [DATA_W-1:0] ramWrData,
  input  logic              doneRead,
  output logic              doneFlag
);
  ctrlStrobe_t strobe;

  safeload_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrSlot(hostWrSlot),
    .initReq(initReq), .windowStart(windowStart), .strobe(strobe),
    .pending(pending), .hostWrReject(hostWrReject)
  );

  safeload_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWrSlot(hostWrSlot),
    .hostWrAddr(hostWrAddr), .hostWrData(hostWrData), .doneRead(doneRead),
    .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData),
    .doneFlag(doneFlag)
  );
endmodule

// File: rtl/safeload_chk.sv
module safeload_chk
  import safeload_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWrEn,
  input logic [IDX_W-1:0]  hostWrSlot,
  input logic [ADDR_W-1:0] hostWrAddr,
  input logic [DATA_W-1:0] hostWrData,
  input logic              hostWrReject,
  input logic              initReq,
  input logic              pending,
  input logic              windowStart,
  input logic              ramWrEn,
  input logic [ADDR_W-1:0] ramWrAddr,
  input logic [DATA_W-1:0] ramWrData,
  input logic              doneRead,
  input logic              doneFlag
);
  // R4
  ram_write_in_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> pending);

  // R3
  arm_from_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> $past(initReq));

  // R6
  done_on_finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pending) |-> doneFlag);

  // R8
  reject_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && pending) |-> hostWrReject);

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && doneRead && !pending) |=> !doneFlag);

  // R9
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pending && windowStart) |-> !ramWrEn);
endmodule

bind safeload_unit safeload_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/safeload_unit_test.sv
module safeload_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [2:0]  hostWrSlot = '0;
  logic [7:0]  hostWrAddr = '0;
  logic [21:0] hostWrData = '0;
  logic        hostWrReject;
  logic        initReq = 1'b0;
  logic        pending;
  logic        windowStart = 1'b0;
  logic        ramWrEn;
  logic [7:0]  ramWrAddr;
  logic [21:0] ramWrData;
  logic        doneRead = 1'b0;
  logic        doneFlag;

  int checks = 0;
  int failures = 0;

  // reference model state
  bit          mArmed = 0;
  bit          mDone = 0;
  int          mPhase = -1;
  bit          mLoaded [5];
  logic [7:0]  mAddr [5];
  logic [21:0] mData [5];

  always #5 clk = ~clk;

  safeload_unit uut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrSlot(hostWrSlot),
    .hostWrAddr(hostWrAddr), .hostWrData(hostWrData), .hostWrReject(hostWrReject),
    .initReq(initReq), .pending(pending), .windowStart(windowStart),
    .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData),
    .doneRead(doneRead), .doneFlag(doneFlag)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // compare one cycle against the model, advance the model, step the clock
  task automatic tick();
    int  cur;
    bit  eWr;
    bit  accept;
    #1;
    cur = -1;
    if (mPhase >= 0) cur = mPhase;
    else if (mArmed && windowStart) cur = 0;
    eWr = (cur >= 0) && mLoaded[cur];
    accept = hostWrEn && !mArmed && (hostWrSlot < 5);
    check("R8", "hostWrReject", 32'(hostWrReject), 32'(hostWrEn && !accept));
    check("R3", "pending", 32'(pending), 32'(mArmed));
    check("R7", "doneFlag", 32'(doneFlag), 32'(mDone));
    check(eWr ? "R4" : "R5", "ramWrEn", 32'(ramWrEn), 32'(eWr));
    if (eWr) begin
      check("R2", "ramWrAddr", 32'(ramWrAddr), 32'(mAddr[cur]));
      check("R2", "ramWrData", 32'(ramWrData), 32'(mData[cur]));
    end
    // next state
    if (cur == 4) begin
      mArmed = 0; mPhase = -1; mDone = 1;
      for (int k = 0; k < 5; k++) mLoaded[k] = 0;
    end else begin
      if (cur >= 0) mPhase = cur + 1;
      if (doneRead) mDone = 0;
    end
    if (accept) begin
      mLoaded[hostWrSlot] = 1;
      mAddr[hostWrSlot] = hostWrAddr;
      mData[hostWrSlot] = hostWrData;
    end
    if (initReq && !mArmed && cur < 0) mArmed = 1;
    @(posedge clk);
    #1;
  endtask

  task automatic clearIns();
    hostWrEn = 0; initReq = 0; windowStart = 0; doneRead = 0;
  endtask

  task automatic idle(int n);
    clearIns();
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic load(int slot, int addr, int data);
    clearIns();
    hostWrEn = 1; hostWrSlot = 3'(slot); hostWrAddr = 8'(addr); hostWrData = 22'(data);
    tick();
    clearIns();
  endtask

  task automatic arm();
    clearIns(); initReq = 1; tick(); clearIns();
  endtask

  task automatic window();
    clearIns(); windowStart = 1; tick(); clearIns();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    for (int k = 0; k < 5; k++) begin mLoaded[k] = 0; mAddr[k] = '0; mData[k] = '0; end
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1", "pending in reset", 32'(pending), 0);
    check("R1", "doneFlag in reset", 32'(doneFlag), 0);
    check("R1", "ramWrEn in reset", 32'(ramWrEn), 0);
    check("R1", "hostWrReject in reset", 32'(hostWrReject), 0);
    rstN = 1;
    @(posedge clk); #1;
    idle(2);
    // R1: no slot loaded after reset, so a transfer writes nothing
    arm(); idle(2); window(); idle(6);
    doneRead = 1; tick(); clearIns();

    // R2 R4: full set of five coefficients
    for (int k = 0; k < 5; k++) load(k, 8'h40 + k, 22'h100000 + k * 22'h1111);
    arm(); idle(3);
    windowStart = 1; tick(); clearIns();
    idle(6);
    doneRead = 1; tick(); clearIns(); idle(1);

    // R5 partial set, R2 overwrite of slot 1
    load(1, 8'h10, 22'h0AAAA);
    load(3, 8'hFF, 22'h3FFFFF);
    load(1, 8'h11, 22'h15555);
    arm(); window(); idle(5);

    // R6 rearm without loads -> nothing written; R7 read at completion edge
    arm(); idle(1);
    window(); idle(3);
    doneRead = 1; tick(); clearIns(); idle(2);
    doneRead = 1; tick(); clearIns(); idle(1);

    // R8 writes while pending and out-of-range slot; R9 init while pending
    load(6, 8'h22, 22'h1234);
    load(0, 8'h01, 22'h000001);
    arm();
    load(2, 8'h55, 22'h5555);
    initReq = 1; tick(); clearIns();
    window(); idle(1);
    initReq = 1; windowStart = 1; tick(); clearIns();
    idle(4);

    // R9 windowStart while idle; init coinciding with a window while idle
    load(4, 8'h99, 22'h2ABCDE);
    window(); idle(1);
    initReq = 1; windowStart = 1; tick(); clearIns();
    idle(2); window(); idle(5);

    // randomized traffic against the model
    for (int i = 0; i < 3000; i++) begin
      hostWrEn    = ($urandom_range(0, 3) == 0);
      hostWrSlot  = 3'($urandom_range(0, 6));
      hostWrAddr  = 8'($urandom);
      hostWrData  = 22'($urandom);
      initReq     = ($urandom_range(0, 9) == 0);
      windowStart = ($urandom_range(0, 7) == 0);
      doneRead    = ($urandom_range(0, 5) == 0);
      tick();
    end
    clearIns();
    idle(2);
    summary();
  end
endmodule